// File: doc/BRIEF.md
# Dual Input Tape Reader with Halt Control

This unit serves the read instruction of a small word-oriented processor. The core asks for the next word from one of two input streams: stream 0 carries the primary input and stream 1 carries the auxiliary input. The unit takes the word from the chosen stream and returns it one cycle later. A flag comes back with it. The flag is clear when a real word was delivered. It is set, and the returned word is zero, when the stream has run dry or when the index names neither stream. Running out of words is a normal outcome and not an error. Once a stream has signalled its end, the unit remembers this until reset. Every later read of that stream returns the empty result at once, and the stream is not looked at again.

Each stream arrives as valid/ready words plus a level `end` signal, which means no word remains. If `valid` and `end` are both high, `valid` wins. The read request is also valid/ready. `rd_ready` is high in the cycle the unit accepts the request, and the requester must drop or change `rd_valid` after that edge. A request is held off with `rd_ready` low for as long as the chosen stream shows neither `valid` nor `end`. There is no back-pressure on the result. It appears for one cycle with `rd_done` and stays on `rd_data`/`rd_flag` until the next completion.

The same unit holds the halt logic for the answer instruction. An answer stores its operand as the return value and freezes the unit: `halted` tells the core to stop advancing its program counter. The run counts as accepted only when the operand is zero.

Top module: `tape_read_unit`

## Requirements
- R1: A read of stream s (index 0 or 1) whose stream shows `valid` is accepted in that cycle. `sN_ready` pulses in that same cycle. One cycle later `rd_done` is 1, `rd_data` equals the stream word and `rd_flag` is 0.
- R2: While the chosen stream shows neither `valid` nor `end`, `rd_ready`, both stream readies and `rd_done` stay 0. The request waits.
- R3: A read of a non-exhausted stream that shows `end` without `valid` completes with `rd_data` zero and `rd_flag` 1. It does not assert that stream's ready.
- R4: After R3 has happened for a stream, every later read of it completes in one cycle with zero and flag 1, and never asserts its ready, even if the stream shows `valid` again. Only reset clears this.
- R5: A read whose index is 2 or more completes in one cycle with zero and flag 1 and asserts neither stream ready.
- R6: Whenever `rd_done` is 1 with `rd_flag` 1, `rd_data` is zero.
- R7: `ans_valid` while not halted sets `halted` on the next edge and stores `ans_value` into `ret_value`.
- R8: `accepted` becomes 1 with the halt exactly when the stored answer value is zero.
- R9: Once halted, read requests are ignored: `rd_ready`, `rd_done` and the stream readies stay 0. Further answers are ignored, and `halted`, `accepted` and `ret_value` hold until reset.
- R10: When `ans_valid` and `rd_valid` are high in the same cycle, the answer wins and the read is not accepted.
- R11: The exhaustion of one stream does not affect reads of the other.
- R12: After reset, `halted`, `accepted`, `ret_value`, `rd_done`, `rd_data` and `rd_flag` are 0, and no stream is exhausted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_valid | input | 1 | Read request present |
| rd_tape | input | IDX_W | Stream index operand |
| rd_ready | output | 1 | Read request accepted this cycle |
| rd_done | output | 1 | One-cycle result strobe |
| rd_data | output | W | Returned word |
| rd_flag | output | 1 | Set when no word was delivered |
| s0_valid | input | 1 | Primary stream word present |
| s0_data | input | W | Primary stream word |
| s0_end | input | 1 | Primary stream has no remaining word |
| s0_ready | output | 1 | Primary stream word consumed |
| s1_valid | input | 1 | Auxiliary stream word present |
| s1_data | input | W | Auxiliary stream word |
| s1_end | input | 1 | Auxiliary stream has no remaining word |
| s1_ready | output | 1 | Auxiliary stream word consumed |
| ans_valid | input | 1 | Answer instruction issued |
| ans_value | input | W | Answer operand |
| halted | output | 1 | Execution stopped; program counter must hold |
| accepted | output | 1 | Halt was caused by a zero answer |
| ret_value | output | W | Latched answer operand |

## Verification
Two situations cannot be reached by ordinary traffic. The first is a stream that offers words again after it has signalled its end. The stimulus model drives `valid` with junk data on every read of an exhausted stream, and expects the empty result with the ready held low. The second is the collision of an answer with a pending read. Because a halt lasts until reset, the run is split into two reset phases. One ends with a zero answer that collides with a live read. The other ends with a non-zero answer, followed by read and answer attempts that must have no effect.

// File: rtl/tape_rd_pkg.sv
package tape_rd_pkg;
  localparam int NUM_TAPES = 2;
endpackage

// File: rtl/tape_lane.sv
module tape_lane #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         pick,
  input  logic         s_valid,
  input  logic [W-1:0] s_data,
  input  logic         s_end,
  output logic         s_ready,
  output logic         can_finish,
  output logic         has_word,
  output logic [W-1:0] word
);
  logic dry_q;

  assign has_word   = s_valid & ~dry_q;
  assign can_finish = dry_q | s_valid | s_end;
  assign s_ready    = pick & has_word;
  assign word       = s_data;

  always_ff @(posedge clk) begin
    if (!rst_n)                                  dry_q <= 1'b0;
    else if (pick && !dry_q && !s_valid && s_end) dry_q <= 1'b1;
  end

  // R4
  dry_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dry_q |=> dry_q);
  // R4
  dry_no_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dry_q |-> !s_ready);
endmodule

// File: rtl/halt_ctrl.sv
module halt_ctrl #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ans_valid,
  input  logic [W-1:0] ans_value,
  output logic         halted,
  output logic         accepted,
  output logic [W-1:0] ret_value
);
  logic take;
  assign take = ans_valid & ~halted;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      halted    <= 1'b0;
      accepted  <= 1'b0;
      ret_value <= '0;
    end else if (take) begin
      halted    <= 1'b1;
      accepted  <= (ans_value == '0);
      ret_value <= ans_value;
    end
  end

  // R9
  halt_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> halted && $stable(accepted) && $stable(ret_value));
  // R8
  accept_rule_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(halted) |-> (accepted == (ret_value == '0)));
  // R7
  halt_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ans_valid && !halted) |=> halted && ret_value == $past(ans_value));
endmodule

// File: rtl/tape_read_unit.sv
module tape_read_unit
  import tape_rd_pkg::*;
#(
  parameter int W     = 32,
  parameter int IDX_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rd_valid,
  input  logic [IDX_W-1:0] rd_tape,
  output logic             rd_ready,
  output logic             rd_done,
  output logic [W-1:0]     rd_data,
  output logic             rd_flag,
  input  logic             s0_valid,
  input  logic [W-1:0]     s0_data,
  input  logic             s0_end,
  output logic             s0_ready,
  input  logic             s1_valid,
  input  logic [W-1:0]     s1_data,
  input  logic             s1_end,
  output logic             s1_ready,
  input  logic             ans_valid,
  input  logic [W-1:0]     ans_value,
  output logic             halted,
  output logic             accepted,
  output logic [W-1:0]     ret_value
);
  localparam int LANES = NUM_TAPES;

  logic         in_valid [LANES];
  logic [W-1:0] in_data  [LANES];
  logic         in_end   [LANES];
  logic         out_rdy  [LANES];
  logic         fin      [LANES];
  logic         hit      [LANES];
  logic [W-1:0] lword    [LANES];
  logic         pick     [LANES];

  assign in_valid[0] = s0_valid;
  assign in_data[0]  = s0_data;
  assign in_end[0]   = s0_end;
  assign in_valid[1] = s1_valid;
  assign in_data[1]  = s1_data;
  assign in_end[1]   = s1_end;
  assign s0_ready    = out_rdy[0];
  assign s1_ready    = out_rdy[1];

  logic live, idx_ok;
  assign live   = rd_valid & ~halted & ~ans_valid;
  assign idx_ok = (rd_tape < IDX_W'(LANES));

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign pick[g] = live & (rd_tape == IDX_W'(g));
    tape_lane #(.W(W)) i_lane (
      .clk       (clk),
      .rst_n     (rst_n),
      .pick      (pick[g]),
      .s_valid   (in_valid[g]),
      .s_data    (in_data[g]),
      .s_end     (in_end[g]),
      .s_ready   (out_rdy[g]),
      .can_finish(fin[g]),
      .has_word  (hit[g]),
      .word      (lword[g])
    );
  end

  logic         sel_fin, sel_hit;
  logic [W-1:0] sel_word;
  always_comb begin
    sel_fin  = 1'b0;
    sel_hit  = 1'b0;
    sel_word = '0;
    for (int i = 0; i < LANES; i++) begin
      if (rd_tape == IDX_W'(i)) begin
        sel_fin  = fin[i];
        sel_hit  = hit[i];
        sel_word = lword[i];
      end
    end
  end

  logic finish, deliver;
  assign finish   = live & (~idx_ok | sel_fin);
  assign deliver  = live & idx_ok & sel_hit;
  assign rd_ready = finish;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_done <= 1'b0;
      rd_data <= '0;
      rd_flag <= 1'b0;
    end else begin
      rd_done <= finish;
      if (finish) begin
        rd_data <= deliver ? sel_word : '0;
        rd_flag <= ~deliver;
      end
    end
  end

  halt_ctrl #(.W(W)) i_halt (
    .clk      (clk),
    .rst_n    (rst_n),
    .ans_valid(ans_valid),
    .ans_value(ans_value),
    .halted   (halted),
    .accepted (accepted),
    .ret_value(ret_value)
  );

  // R6
  empty_is_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_done && rd_flag) |-> rd_data == '0);
  // R1
  done_follows_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_done |-> $past(rd_ready));
  // R5
  bad_index_no_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_ready && !idx_ok) |-> !s0_ready && !s1_ready);
  // R9
  halted_no_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    halted |-> !rd_ready && !s0_ready && !s1_ready);
  // R10
  answer_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ans_valid |-> !rd_ready);
endmodule

// File: tb/test_tape_read_unit.sv
module test_tape_read_unit;
  localparam int W = 32;
  localparam int IDX_W = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rd_valid = 1'b0;
  logic [IDX_W-1:0] rd_tape = '0;
  logic rd_ready, rd_done, rd_flag;
  logic [W-1:0] rd_data;
  logic t_valid [2];
  logic [W-1:0] t_data [2];
  logic t_end [2];
  logic t_ready [2];
  logic ans_valid = 1'b0;
  logic [W-1:0] ans_value = '0;
  logic halted, accepted;
  logic [W-1:0] ret_value;

  int checks = 0;
  int fails = 0;
  int rem [2];
  bit dry [2];

  always #4 clk = ~clk;

  tape_read_unit #(.W(W), .IDX_W(IDX_W)) i_tape_read_unit (
    .clk(clk), .rst_n(rst_n),
    .rd_valid(rd_valid), .rd_tape(rd_tape), .rd_ready(rd_ready),
    .rd_done(rd_done), .rd_data(rd_data), .rd_flag(rd_flag),
    .s0_valid(t_valid[0]), .s0_data(t_data[0]), .s0_end(t_end[0]), .s0_ready(t_ready[0]),
    .s1_valid(t_valid[1]), .s1_data(t_data[1]), .s1_end(t_end[1]), .s1_ready(t_ready[1]),
    .ans_valid(ans_valid), .ans_value(ans_value),
    .halted(halted), .accepted(accepted), .ret_value(ret_value)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic bit bad_index(input int idx);
    return idx >= 2;
  endfunction

  task automatic clear_tapes();
    for (int i = 0; i < 2; i++) begin
      t_valid[i] = 1'b0; t_data[i] = '0; t_end[i] = 1'b0;
    end
  endtask

  task automatic do_reset(input int w0, input int w1);
    @(negedge clk);
    rst_n = 1'b0; rd_valid = 1'b0; ans_valid = 1'b0;
    clear_tapes();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    rem[0] = w0; rem[1] = w1; dry[0] = 0; dry[1] = 0;
    @(negedge clk);
    // R12
    chk(!halted && !accepted && ret_value == 0, "R12 halt state", {halted, accepted}, 0);
    chk(!rd_done && rd_data == 0 && !rd_flag, "R12 read result", rd_data, 0);
  endtask

  // entered and left at a negedge
  task automatic do_read(input int idx, input int gaps);
    logic [W-1:0] w;
    rd_valid = 1'b1;
    rd_tape  = IDX_W'(idx);
    if (bad_index(idx) || dry[idx]) begin
      if (!bad_index(idx)) begin
        t_valid[idx] = 1'b1; t_data[idx] = $urandom;   // R4: words reappear
      end
      #1;
      chk(rd_ready && !t_ready[0] && !t_ready[1],
          bad_index(idx) ? "R5 accept no take" : "R4 accept no take", rd_ready, 1);
      @(posedge clk); @(negedge clk);
      rd_valid = 1'b0; clear_tapes();
      chk(rd_done && rd_data == 0 && rd_flag,
          bad_index(idx) ? "R5 empty result" : "R4 empty result", rd_data, 0);
      return;
    end
    for (int g = 0; g < gaps; g++) begin
      t_valid[idx] = 1'b0; t_end[idx] = 1'b0;
      #1;
      chk(!rd_ready && !t_ready[0] && !t_ready[1], "R2 stall", rd_ready, 0);
      @(posedge clk); @(negedge clk);
      chk(!rd_done, "R2 no done", rd_done, 0);
    end
    if (rem[idx] > 0) begin
      w = $urandom;
      t_valid[idx] = 1'b1; t_data[idx] = w;
      #1;
      chk(rd_ready && t_ready[idx] && !t_ready[1-idx], "R1 take", t_ready[idx], 1);
      @(posedge clk); @(negedge clk);
      rd_valid = 1'b0; clear_tapes();
      chk(rd_done && rd_data == w && !rd_flag, "R1 word", rd_data, w);
      rem[idx]--;
    end else begin
      t_end[idx] = 1'b1;
      #1;
      chk(rd_ready && !t_ready[idx], "R3 end accept", rd_ready, 1);
      @(posedge clk); @(negedge clk);
      rd_valid = 1'b0; clear_tapes();
      chk(rd_done && rd_data == 0 && rd_flag, "R3 end result", rd_data, 0);
      chk(!rd_flag || rd_data == 0, "R6 flag zero", rd_data, 0);
      dry[idx] = 1;
    end
  endtask

  task automatic do_answer(input logic [W-1:0] v, input bit with_read);
    bit was_halted = halted;
    logic [W-1:0] old_ret = ret_value;
    bit old_acc = accepted;
    ans_valid = 1'b1; ans_value = v;
    if (with_read) begin
      rd_valid = 1'b1; rd_tape = 0; t_valid[0] = 1'b1; t_data[0] = 32'h1234;
      #1;
      chk(!rd_ready && !t_ready[0], "R10 answer wins", rd_ready, 0);
    end
    @(posedge clk); @(negedge clk);
    ans_valid = 1'b0; rd_valid = 1'b0; clear_tapes();
    if (with_read) chk(!rd_done, "R10 no done", rd_done, 0);
    if (!was_halted) begin
      chk(halted && ret_value == v, "R7 halt capture", ret_value, v);
      chk(accepted == (v == 0), "R8 accept rule", accepted, v == 0);
    end else begin
      chk(halted && ret_value == old_ret && accepted == old_acc, "R9 answer ignored", ret_value, old_ret);
    end
  endtask

  task automatic read_after_halt();
    rd_valid = 1'b1; rd_tape = 0; t_valid[0] = 1'b1; t_data[0] = 32'hABCD;
    for (int k = 0; k < 2; k++) begin
      #1;
      chk(!rd_ready && !t_ready[0] && !t_ready[1], "R9 read ignored", rd_ready, 0);
      @(posedge clk); @(negedge clk);
      chk(!rd_done, "R9 no done", rd_done, 0);
    end
    rd_valid = 1'b0; clear_tapes();
  endtask

  initial begin
    void'($urandom(32'd20240611));
    clear_tapes();
    do_reset(12, 3);
    // directed corners
    do_read(1, 3);
    do_read(255, 0);
    do_read(0, 0);
    do_read(1, 1); do_read(1, 0);
    do_read(1, 2);            // R3: stream 1 ends
    do_read(1, 0);            // R4
    do_read(0, 1);            // R11: stream 0 still delivers
    // constrained random mix
    for (int n = 0; n < 60; n++) begin
      int idx;
      idx = ($urandom % 8 == 0) ? 2 + int'($urandom % 3) : int'($urandom % 2);
      do_read(idx, int'($urandom % 3));
    end
    do_answer(0, 1);
    read_after_halt();
    do_answer(32'h9, 0);
    // second phase: non-zero answer
    do_reset(2, 1);
    do_read(0, 0);
    do_read(1, 0);
    do_read(1, 0);
    do_answer(32'h5A, 0);
    chk(!accepted, "R8 non-zero not accepted", accepted, 0);
    read_after_halt();
    do_answer(0, 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(8 * 200000);
    checks++; fails++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule